// File: doc/BRIEF.md
# Three-Stage Pipeline Hazard Controller

This block steers operand bypassing, stalls and control-flow recovery for a pipeline with three stages. The fetch stage reads the instruction memory at the PC into an instruction register. The execute stage decodes, reads registers and runs the ALU, including branch targets and comparisons. The memory stage accesses data memory and writes the register file at the end of its cycle. The controller looks at the source registers and opcode of the execute-stage instruction, the resolved taken flag, and the destination, write enable and load flag of the memory-stage instruction. From these it produces operand selects, a hold for the PC and instruction register, a bubble for the memory stage, a squash for the fetched instruction, and a PC target select.

An ALU result in the memory stage is bypassed straight to the dependent operand. A dependent instruction that follows a load is held for one cycle while a nop goes to the memory stage. In the next cycle the captured load data feeds the ALU input. Branches are predicted not taken. A taken branch, and every jal or jalr, squashes the single instruction behind it and redirects the PC.

Top module: `pipe_hazard_ctl`

## Requirements
- R1: When the memory stage writes (write enable 1, load flag 0) a nonzero destination that equals a source the execute-stage opcode uses, that operand select is 1 (ALU result bypass). Operand A follows rs1 and operand B follows rs2.
- R2: When the memory-stage instruction is a load with write enable 1 and a nonzero destination that equals a used source, stall and bubble are 1, and kill and PC select are 0.
- R3: In the cycle right after a stall, an operand whose source equals the stalled load's destination selects 2 (load data). Select 2 occurs in no other cycle.
- R4: A source field is ignored when the opcode does not read it. OP (0110011), BRANCH (1100011) and STORE (0100011) read rs1 and rs2. OP-IMM (0010011), LOAD (0000011) and JALR (1100111) read only rs1. All other opcodes read neither. A load that matches no used source causes no stall.
- R5: Register 0 is never bypassed and never causes a stall, either as a source or as a destination.
- R6: A memory-stage instruction with write enable 0 causes no bypass and no stall, even when its load flag is 1.
- R7: A BRANCH with the taken flag at 1 drives kill 1 and PC select 1. With the taken flag at 0, both stay 0.
- R8: JAL (1101111) and JALR drive kill 1 and PC select 1 whatever the taken flag.
- R9: Stall and redirect are never asserted together. A control-flow instruction that waits on a load stalls first and redirects in the following cycle.
- R10: While reset is high, bubble and kill are 1 and stall, PC select and both operand selects are 0. Reset also clears any pending load bypass.
- R11: With no dependency, both operand selects are 0 (register file).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_rs1_i | input | 5 | rs1 field of the execute-stage instruction |
| x_rs2_i | input | 5 | rs2 field of the execute-stage instruction |
| x_opcode_i | input | 7 | Opcode of the execute-stage instruction |
| x_taken_i | input | 1 | Branch comparison result for the execute-stage instruction |
| m_rd_i | input | 5 | Destination of the memory-stage instruction |
| m_we_i | input | 1 | Register write enable of the memory-stage instruction |
| m_load_i | input | 1 | Memory-stage instruction is a load |
| fwd_a_o | output | 2 | Operand A source: 0 register file, 1 ALU bypass, 2 load data |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Hold PC, instruction register and execute stage |
| bubble_o | output | 1 | Insert nop into the memory stage |
| kill_o | output | 1 | Turn the fetched instruction into a nop entering execute |
| pc_sel_o | output | 1 | 1 selects the computed target for the next PC |

## Verification
The only internal state is the pending-load flag and its captured destination. If either is wrong, the error shows at the operand selects in the single cycle after a stall: a missing or stale load select there, or a spurious select 2 later. Errors in the decode or the comparators appear in the same cycle as the offending inputs, as a wrong select, a missing stall, or a redirect during a stall. The bench probes the ignored source fields, register 0 and the disabled writes so that a wrong match shows up directly.

// File: rtl/hz_pkg.sv
package hz_pkg;
    localparam int OPC_W = 7;

    typedef enum logic [1:0] {
        FWD_REG  = 2'd0,
        FWD_ALU  = 2'd1,
        FWD_LOAD = 2'd2
    } fwd_e;

    localparam logic [OPC_W-1:0] OPC_OP     = 7'b0110011;
    localparam logic [OPC_W-1:0] OPC_OPIMM  = 7'b0010011;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 7'b0000011;
    localparam logic [OPC_W-1:0] OPC_STORE  = 7'b0100011;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 7'b1100011;
    localparam logic [OPC_W-1:0] OPC_JAL    = 7'b1101111;
    localparam logic [OPC_W-1:0] OPC_JALR   = 7'b1100111;
endpackage

// File: rtl/hz_src_decode.sv
module hz_src_decode
    import hz_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output logic [1:0]       use_o,
    output logic             branch_o,
    output logic             jump_o
);
    always_comb begin
        use_o    = 2'b00;
        branch_o = 1'b0;
        jump_o   = 1'b0;
        case (opcode_i)
            OPC_OP, OPC_STORE:            use_o = 2'b11;
            OPC_BRANCH: begin
                use_o    = 2'b11;
                branch_o = 1'b1;
            end
            OPC_OPIMM, OPC_LOAD:          use_o = 2'b01;
            OPC_JALR: begin
                use_o  = 2'b01;
                jump_o = 1'b1;
            end
            OPC_JAL:                      jump_o = 1'b1;
            default:                      use_o = 2'b00;
        endcase
    end
endmodule

// File: rtl/hz_operand_fwd.sv
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          use_i,
    input  logic [AW-1:0] rs_i,
    input  logic [AW-1:0] m_rd_i,
    input  logic          m_we_i,
    input  logic          m_load_i,
    input  logic          ldp_i,
    input  logic [AW-1:0] ld_rd_i,
    output fwd_e          sel_o,
    output logic          luse_o
);
    logic live_src, m_hit, p_hit;

    always_comb begin
        live_src = use_i && (rs_i != '0);
        m_hit    = live_src && m_we_i && (m_rd_i == rs_i);
        p_hit    = live_src && ldp_i && (ld_rd_i == rs_i);
        luse_o   = !rst && m_hit && m_load_i;
        if (rst)                    sel_o = FWD_REG;
        else if (m_hit && !m_load_i) sel_o = FWD_ALU;
        else if (p_hit)             sel_o = FWD_LOAD;
        else                        sel_o = FWD_REG;
    end

    // R5: register 0 never bypasses or stalls
    a_r5_zero_src: assert property (@(posedge clk) disable iff (rst)
        (rs_i == '0) |-> (sel_o == FWD_REG && !luse_o));
    // R4: an unread source field has no effect
    a_r4_unused_src: assert property (@(posedge clk) disable iff (rst)
        !use_i |-> (sel_o == FWD_REG && !luse_o));
    // R6: no write, no pending load -> register file
    a_r6_no_write: assert property (@(posedge clk) disable iff (rst)
        (!m_we_i && !ldp_i) |-> (sel_o == FWD_REG && !luse_o));
endmodule

// File: rtl/pipe_hazard_ctl.sv
module pipe_hazard_ctl
    import hz_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    x_rs1_i,
    input  logic [AW-1:0]    x_rs2_i,
    input  logic [OPC_W-1:0] x_opcode_i,
    input  logic             x_taken_i,
    input  logic [AW-1:0]    m_rd_i,
    input  logic             m_we_i,
    input  logic             m_load_i,
    output logic [1:0]       fwd_a_o,
    output logic [1:0]       fwd_b_o,
    output logic             stall_o,
    output logic             bubble_o,
    output logic             kill_o,
    output logic             pc_sel_o
);
    localparam int NSRC = 2;

    typedef struct packed {
        logic          ld_pend;
        logic [AW-1:0] ld_rd;
    } state_t;

    state_t state_d, state_q;

    logic [NSRC-1:0]   use_v;
    logic [NSRC-1:0]   luse_v;
    logic [AW-1:0]     rs_v [NSRC];
    fwd_e              sel_v [NSRC];
    logic              is_branch, is_jump, hazard, redirect;

    assign rs_v[0] = x_rs1_i;
    assign rs_v[1] = x_rs2_i;

    hz_src_decode u_dec (
        .opcode_i (x_opcode_i),
        .use_o    (use_v),
        .branch_o (is_branch),
        .jump_o   (is_jump)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hz_operand_fwd #(.AW(AW)) u_fwd (
            .clk      (clk),
            .rst      (rst),
            .use_i    (use_v[g]),
            .rs_i     (rs_v[g]),
            .m_rd_i   (m_rd_i),
            .m_we_i   (m_we_i),
            .m_load_i (m_load_i),
            .ldp_i    (state_q.ld_pend),
            .ld_rd_i  (state_q.ld_rd),
            .sel_o    (sel_v[g]),
            .luse_o   (luse_v[g])
        );
    end

    always_comb begin
        hazard   = |luse_v;
        redirect = !rst && !hazard && (is_jump || (is_branch && x_taken_i));
        stall_o  = !rst && hazard;
        bubble_o = rst || stall_o;
        kill_o   = rst || redirect;
        pc_sel_o = redirect;
        fwd_a_o  = sel_v[0];
        fwd_b_o  = sel_v[1];

        state_d         = state_q;
        state_d.ld_pend = stall_o;
        if (stall_o) state_d.ld_rd = m_rd_i;
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // R2: a stall is a bubble with no squash and no redirect
    a_r2_stall_shape: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (bubble_o && !kill_o && !pc_sel_o));
    // R9: stall and redirect are exclusive
    a_r9_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(stall_o && pc_sel_o));
    // R7: a redirect always squashes the fetched instruction
    a_r7_redirect_kills: assert property (@(posedge clk) disable iff (rst)
        pc_sel_o |-> kill_o);
    // R8: jal has no sources, so it always redirects
    a_r8_jal_redirect: assert property (@(posedge clk) disable iff (rst)
        (x_opcode_i == OPC_JAL) |-> pc_sel_o);
    // R3: load-data select only in the cycle after a stall
    a_r3_load_after_stall: assert property (@(posedge clk) disable iff (rst)
        (fwd_a_o == FWD_LOAD || fwd_b_o == FWD_LOAD) |-> $past(stall_o));
    // R10: reset output state
    a_r10_reset_outputs: assert property (@(posedge clk)
        rst |-> (bubble_o && kill_o && !stall_o && !pc_sel_o
                 && fwd_a_o == 2'd0 && fwd_b_o == 2'd0));
endmodule

// File: tb/pipe_hazard_ctl_tb.sv
module pipe_hazard_ctl_tb;
    typedef struct packed {
        logic [7:0] req;
        logic [4:0] rs1;
        logic [4:0] rs2;
        logic [6:0] opc;
        logic       tk;
        logic [4:0] mrd;
        logic       mwe;
        logic       mld;
        logic [7:0] exp;   // {fwd_a, fwd_b, stall, bubble, kill, pc_sel}
    } vec_t;

    localparam logic [6:0] OP = 7'b0110011, BR = 7'b1100011, JL = 7'b1101111,
                           JR = 7'b1100111, LU = 7'b0110111, ST = 7'b0100011,
                           IM = 7'b0010011;
    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{8'd11, 5'd1, 5'd2, OP, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_00_0000}, // R11
        '{8'd1,  5'd3, 5'd2, OP, 1'b0, 5'd3, 1'b1, 1'b0, 8'b01_00_0000}, // R1 a
        '{8'd1,  5'd2, 5'd3, OP, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_01_0000}, // R1 b
        '{8'd1,  5'd3, 5'd3, OP, 1'b0, 5'd3, 1'b1, 1'b0, 8'b01_01_0000}, // R1 both
        '{8'd6,  5'd3, 5'd3, OP, 1'b0, 5'd3, 1'b0, 1'b0, 8'b00_00_0000}, // R6
        '{8'd5,  5'd0, 5'd0, OP, 1'b0, 5'd0, 1'b1, 1'b0, 8'b00_00_0000}, // R5
        '{8'd4,  5'd3, 5'd3, LU, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_00_0000}, // R4 lui
        '{8'd4,  5'd1, 5'd3, IM, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_00_0000}, // R4 imm
        '{8'd4,  5'd1, 5'd2, OP, 1'b0, 5'd5, 1'b1, 1'b1, 8'b00_00_0000}, // R4 indep load
        '{8'd2,  5'd5, 5'd2, OP, 1'b0, 5'd5, 1'b1, 1'b1, 8'b00_00_1100}, // R2
        '{8'd3,  5'd5, 5'd2, OP, 1'b0, 5'd0, 1'b0, 1'b0, 8'b10_00_0000}, // R3
        '{8'd3,  5'd5, 5'd2, OP, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_00_0000}, // R3 once
        '{8'd5,  5'd0, 5'd0, OP, 1'b0, 5'd0, 1'b1, 1'b1, 8'b00_00_0000}, // R5 load x0
        '{8'd7,  5'd1, 5'd2, BR, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_00_0000}, // R7 not taken
        '{8'd7,  5'd3, 5'd2, BR, 1'b1, 5'd3, 1'b1, 1'b0, 8'b01_00_0011}, // R7 taken
        '{8'd8,  5'd3, 5'd3, JL, 1'b0, 5'd3, 1'b1, 1'b0, 8'b00_00_0011}, // R8 jal
        '{8'd8,  5'd3, 5'd5, JR, 1'b0, 5'd9, 1'b1, 1'b1, 8'b00_00_0011}, // R8 jalr
        '{8'd9,  5'd1, 5'd4, BR, 1'b1, 5'd4, 1'b1, 1'b1, 8'b00_00_1100}, // R9 wait
        '{8'd9,  5'd1, 5'd4, BR, 1'b1, 5'd0, 1'b0, 1'b0, 8'b00_10_0011}, // R9 then go
        '{8'd2,  5'd6, 5'd7, ST, 1'b0, 5'd7, 1'b1, 1'b1, 8'b00_00_1100}, // R2 store
        '{8'd3,  5'd6, 5'd7, ST, 1'b0, 5'd0, 1'b0, 1'b0, 8'b00_10_0000}, // R3 store
        '{8'd6,  5'd5, 5'd5, OP, 1'b0, 5'd5, 1'b0, 1'b1, 8'b00_00_0000}  // R6 load off
    };

    logic clk = 1'b0, rst = 1'b1;
    logic [4:0] x_rs1, x_rs2, m_rd;
    logic [6:0] x_opc;
    logic x_tk, m_we, m_ld;
    logic [1:0] fwd_a, fwd_b;
    logic stall, bubble, kill, pc_sel;
    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pipe_hazard_ctl u_dut (
        .clk(clk), .rst(rst), .x_rs1_i(x_rs1), .x_rs2_i(x_rs2),
        .x_opcode_i(x_opc), .x_taken_i(x_tk), .m_rd_i(m_rd), .m_we_i(m_we),
        .m_load_i(m_ld), .fwd_a_o(fwd_a), .fwd_b_o(fwd_b), .stall_o(stall),
        .bubble_o(bubble), .kill_o(kill), .pc_sel_o(pc_sel)
    );

    task automatic drive(input vec_t v);
        x_rs1 = v.rs1; x_rs2 = v.rs2; x_opc = v.opc; x_tk = v.tk;
        m_rd = v.mrd; m_we = v.mwe; m_ld = v.mld;
    endtask

    task automatic check(input string tag, input logic [7:0] exp);
        logic [7:0] act;
        act = {fwd_a, fwd_b, stall, bubble, kill, pc_sel};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        drive(VEC[9]);   // load-use pattern held during reset
        repeat (2) @(negedge clk);
        #2 check("R10 reset outputs", 8'b00_00_0110);
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            #2 check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].exp);
            @(negedge clk);
        end
        // R10: reset clears a pending load bypass
        drive(VEC[9]);
        #2 check("R2 before reset", 8'b00_00_1100);
        @(negedge clk);
        rst = 1'b1;
        drive(VEC[10]);
        #2 check("R10 reset masks pending", 8'b00_00_0110);
        @(negedge clk);
        rst = 1'b0;
        #2 check("R10 pending cleared", 8'b00_00_0000);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule